// File: doc/BRIEF.md
# Link Mode Switch for a Mesh Router

This block sits between a mesh router's four link ports (north, south, east, west) and the physical link wires. It decides, port by port, what the wires of that link carry. In packet mode the wires carry ordinary flits with valid/ready flow control. In bus mode the link is joined into a segmented snooping bus. Each port's mode is programmed on its own, so some ports can form part of a bus while the rest keep carrying packets.

In bus mode both unidirectional channels of a link act as one bidirectional segment that is twice the flit width. The router's output on that port is refused by holding ready low, so the flit waits in the router buffer. Router input from that port is also gated off. Tri-state wires are modelled as a value plus an output enable, and received values are OR-combined. Whichever side owns the bus at a given moment sets the direction on every segment. The request, busy and grant arbitration lines of bus-mode ports are joined at this node in the same way as the data, so that joined segments form one arbitration network.

A new mode requested for a port is applied at a clock edge only when three conditions hold. No outgoing packet on that port may be part-way through. No flit may be handed over on that port in that cycle. No bus transaction may be in progress at this node. Until then the request stays pending.

Top module: `link_mode_switch`

## Requirements
- R1: While reset is active and right after it, every port is in packet mode (mode_o = 0), drives only the low half of its link (lnk_oe_o = 2'b01), and drives no arbitration line.
- R2: A port in packet mode (mode bit 0) carries the router flit on lnk_d_o[FLIT_W-1:0], drives zero on the upper half, sets lnk_valid_o from rtr_valid_i and rtr_ready_o from lnk_ready_i. It delivers lnk_d_i[2*FLIT_W-1:FLIT_W] with lnk_valid_i to the router, and passes rtr_in_ready_i to lnk_ready_o.
- R3: A port in bus mode (mode bit 1) holds rtr_ready_o, lnk_valid_o, lnk_ready_o and rtr_in_valid_o low and presents an all-zero rtr_in_flit_o.
- R4: When the local node drives the bus (loc_drive_i = 1), every bus-mode port sets lnk_oe_o = 2'b11 and carries the local value on all 2*FLIT_W wires.
- R5: A bus-mode port drives outward the OR of the local value (when local drives) and the values received on the other bus-mode ports whose lnk_den_i is 1. Its enable is 2'b11 only if at least one such source exists, and 2'b00 otherwise. Nothing is echoed back onto the port it came from. loc_rdata_o is the OR of the received values of all driven bus-mode ports.
- R6: On a bus-mode port, each outgoing arbitration line (request, busy, grant) is the OR of the matching local input and the matching inputs of the other bus-mode ports. loc_req_o, loc_busy_o and loc_gnt_o are the OR over bus-mode ports only. Packet-mode ports drive and contribute nothing.
- R7: Each port's mode is set independently; any of the 16 patterns of mode_req_i can be reached.
- R8: After the router hands over a flit with rtr_last_i = 0 on a port, that port's mode does not change until the flit with rtr_last_i = 1 has been handed over.
- R9: While loc_busy_i is 1, or lnk_busy_i is 1 on a bus-mode port, no port changes mode. lnk_busy_i on a packet-mode port does not hold changes back.
- R10: A mode request is applied at the first clock edge at which it is allowed. A flit handed over on a port in the same cycle defers that port's change by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req_i | input | NP | Requested mode per port (1 = bus) |
| mode_o | output | NP | Applied mode per port |
| rtr_flit_i | input | NP x FLIT_W | Router output flit per port |
| rtr_valid_i | input | NP | Router output valid |
| rtr_last_i | input | NP | Router flit is the last of its packet |
| rtr_ready_o | output | NP | Ready back to the router output |
| rtr_in_flit_o | output | NP x FLIT_W | Flit delivered to router input |
| rtr_in_valid_o | output | NP | Valid to router input |
| rtr_in_ready_i | input | NP | Router input ready |
| lnk_d_o | output | NP x 2*FLIT_W | Value driven on link wires |
| lnk_oe_o | output | NP x 2 | Drive enable, one bit per channel half |
| lnk_valid_o | output | NP | Outgoing packet valid |
| lnk_ready_i | input | NP | Outgoing packet ready from neighbour |
| lnk_d_i | input | NP x 2*FLIT_W | Resolved value received on link wires |
| lnk_den_i | input | NP | Far side drives the segment (bus mode) |
| lnk_valid_i | input | NP | Incoming packet valid |
| lnk_ready_o | output | NP | Incoming packet ready to neighbour |
| lnk_req_o | output | NP | Bus request line driven outward |
| lnk_busy_o | output | NP | Bus busy line driven outward |
| lnk_gnt_o | output | NP | Bus grant line driven outward |
| lnk_req_i | input | NP | Bus request line from far side |
| lnk_busy_i | input | NP | Bus busy line from far side |
| lnk_gnt_i | input | NP | Bus grant line from far side |
| loc_wdata_i | input | 2*FLIT_W | Local node bus write value |
| loc_drive_i | input | 1 | Local node owns and drives the bus |
| loc_rdata_o | output | 2*FLIT_W | Bus value seen by the local node |
| loc_req_i | input | 1 | Local bus request |
| loc_busy_i | input | 1 | Local node holds a bus transaction |
| loc_gnt_i | input | 1 | Local grant passed on |
| loc_req_o | output | 1 | Remote request seen on joined bus |
| loc_busy_o | output | 1 | Remote busy seen on joined bus |
| loc_gnt_o | output | 1 | Grant arriving over joined bus |

## Verification
A mode request and a flit handover on the same port can fall into the same cycle. They can also coincide with the handover of a packet's closing flit. The bench raises mode_req_i on a port while the router presents a flit that the neighbour accepts. It then checks at the following falling edge that mode_o has kept its old value, and one edge later that the new mode is in place. A head flit followed by an idle gap checks that the pending request waits for the tail. Busy raised on a packet-mode port, as against a bus-mode port, checks that only joined segments hold the change back.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic {
    LM_PKT = 1'b0,
    LM_BUS = 1'b1
  } link_mode_e;

  // A port may take a new mode when it is idle on both the packet side and the bus side.
  function automatic logic may_switch(input logic mid_pkt, input logic xfer_now,
                                      input logic busy_now);
    return !mid_pkt && !xfer_now && !busy_now;
  endfunction

  // Packet-mode enable pattern: only the outgoing half is driven.
  function automatic logic [1:0] pkt_oe();
    return 2'b01;
  endfunction

endpackage

// File: rtl/lms_port_ctrl.sv
module lms_port_ctrl
  import lms_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req,
  input  logic xfer,
  input  logic last,
  input  logic bus_busy,
  output logic mode,
  output logic pkt_mid,
  output logic sw_ok
);

  assign sw_ok = may_switch(pkt_mid, xfer, bus_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= LM_PKT;
      pkt_mid <= 1'b0;
    end else begin
      if (sw_ok) mode <= mode_req;
      if (xfer)  pkt_mid <= !last;
    end
  end

endmodule

// File: rtl/lms_bus_junction.sv
module lms_bus_junction #(
  parameter int NP = 4,
  parameter int BW = 256
) (
  input  logic [NP-1:0]         bus_en,
  input  logic [NP-1:0][BW-1:0] rx_d,
  input  logic [NP-1:0]         rx_den,
  input  logic [NP-1:0]         rx_req,
  input  logic [NP-1:0]         rx_busy,
  input  logic [NP-1:0]         rx_gnt,
  input  logic [BW-1:0]         loc_wdata,
  input  logic                  loc_drive,
  input  logic                  loc_req,
  input  logic                  loc_busy,
  input  logic                  loc_gnt,
  output logic [NP-1:0][BW-1:0] fwd_d,
  output logic [NP-1:0]         fwd_oe,
  output logic [NP-1:0]         fwd_req,
  output logic [NP-1:0]         fwd_busy,
  output logic [NP-1:0]         fwd_gnt,
  output logic [BW-1:0]         loc_rdata,
  output logic                  loc_req_seen,
  output logic                  loc_busy_seen,
  output logic                  loc_gnt_seen
);

  always_comb begin
    loc_rdata     = '0;
    loc_req_seen  = 1'b0;
    loc_busy_seen = 1'b0;
    loc_gnt_seen  = 1'b0;
    for (int q = 0; q < NP; q++) begin
      if (bus_en[q]) begin
        if (rx_den[q]) loc_rdata = loc_rdata | rx_d[q];
        loc_req_seen  = loc_req_seen  | rx_req[q];
        loc_busy_seen = loc_busy_seen | rx_busy[q];
        loc_gnt_seen  = loc_gnt_seen  | rx_gnt[q];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      fwd_d[p]    = loc_drive ? loc_wdata : '0;
      fwd_oe[p]   = loc_drive;
      fwd_req[p]  = loc_req;
      fwd_busy[p] = loc_busy;
      fwd_gnt[p]  = loc_gnt;
      for (int q = 0; q < NP; q++) begin
        if (q != p && bus_en[q]) begin
          if (rx_den[q]) begin
            fwd_d[p]  = fwd_d[p] | rx_d[q];
            fwd_oe[p] = 1'b1;
          end
          fwd_req[p]  = fwd_req[p]  | rx_req[q];
          fwd_busy[p] = fwd_busy[p] | rx_busy[q];
          fwd_gnt[p]  = fwd_gnt[p]  | rx_gnt[q];
        end
      end
    end
  end

endmodule

// File: rtl/lms_port_mux.sv
module lms_port_mux
  import lms_pkg::*;
#(
  parameter int FW = 128,
  localparam int BW = 2 * FW
) (
  input  logic          mode,
  input  logic [FW-1:0] rtr_flit,
  input  logic          rtr_valid,
  input  logic          rtr_in_ready,
  input  logic [FW-1:0] rx_flit,
  input  logic          rx_valid,
  input  logic          tx_ready,
  input  logic [BW-1:0] fwd_d,
  input  logic          fwd_oe,
  input  logic          fwd_req,
  input  logic          fwd_busy,
  input  logic          fwd_gnt,
  output logic [BW-1:0] lnk_d,
  output logic [1:0]    lnk_oe,
  output logic          lnk_valid,
  output logic          lnk_ready,
  output logic          rtr_ready,
  output logic [FW-1:0] rtr_in_flit,
  output logic          rtr_in_valid,
  output logic          arb_req,
  output logic          arb_busy,
  output logic          arb_gnt
);

  logic on_bus;
  assign on_bus = (mode == LM_BUS);

  always_comb begin
    if (on_bus) begin
      lnk_d        = fwd_d;
      lnk_oe       = {2{fwd_oe}};
      lnk_valid    = 1'b0;
      lnk_ready    = 1'b0;
      rtr_ready    = 1'b0;
      rtr_in_flit  = '0;
      rtr_in_valid = 1'b0;
      arb_req      = fwd_req;
      arb_busy     = fwd_busy;
      arb_gnt      = fwd_gnt;
    end else begin
      lnk_d        = {{FW{1'b0}}, rtr_flit};
      lnk_oe       = pkt_oe();
      lnk_valid    = rtr_valid;
      lnk_ready    = rtr_in_ready;
      rtr_ready    = tx_ready;
      rtr_in_flit  = rx_flit;
      rtr_in_valid = rx_valid;
      arb_req      = 1'b0;
      arb_busy     = 1'b0;
      arb_gnt      = 1'b0;
    end
  end

endmodule

// File: rtl/link_mode_switch.sv
module link_mode_switch
  import lms_pkg::*;
#(
  parameter int NP = 4,
  parameter int FLIT_W = 128,
  localparam int BW = 2 * FLIT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             mode_req_i,
  output logic [NP-1:0]             mode_o,
  input  logic [NP-1:0][FLIT_W-1:0] rtr_flit_i,
  input  logic [NP-1:0]             rtr_valid_i,
  input  logic [NP-1:0]             rtr_last_i,
  output logic [NP-1:0]             rtr_ready_o,
  output logic [NP-1:0][FLIT_W-1:0] rtr_in_flit_o,
  output logic [NP-1:0]             rtr_in_valid_o,
  input  logic [NP-1:0]             rtr_in_ready_i,
  output logic [NP-1:0][BW-1:0]     lnk_d_o,
  output logic [NP-1:0][1:0]        lnk_oe_o,
  output logic [NP-1:0]             lnk_valid_o,
  input  logic [NP-1:0]             lnk_ready_i,
  input  logic [NP-1:0][BW-1:0]     lnk_d_i,
  input  logic [NP-1:0]             lnk_den_i,
  input  logic [NP-1:0]             lnk_valid_i,
  output logic [NP-1:0]             lnk_ready_o,
  output logic [NP-1:0]             lnk_req_o,
  output logic [NP-1:0]             lnk_busy_o,
  output logic [NP-1:0]             lnk_gnt_o,
  input  logic [NP-1:0]             lnk_req_i,
  input  logic [NP-1:0]             lnk_busy_i,
  input  logic [NP-1:0]             lnk_gnt_i,
  input  logic [BW-1:0]             loc_wdata_i,
  input  logic                      loc_drive_i,
  output logic [BW-1:0]             loc_rdata_o,
  input  logic                      loc_req_i,
  input  logic                      loc_busy_i,
  input  logic                      loc_gnt_i,
  output logic                      loc_req_o,
  output logic                      loc_busy_o,
  output logic                      loc_gnt_o
);

  // Internal events, named for the checker
  logic [NP-1:0]         pkt_mid;
  logic [NP-1:0]         sw_ok;
  logic [NP-1:0]         xfer;
  logic                  bus_busy;
  logic [NP-1:0][BW-1:0] fwd_d;
  logic [NP-1:0]         fwd_oe, fwd_req, fwd_busy, fwd_gnt;

  assign xfer     = rtr_valid_i & rtr_ready_o;
  assign bus_busy = loc_busy_i | loc_busy_o;

  lms_bus_junction #(.NP(NP), .BW(BW)) u_junction (
    .bus_en       (mode_o),
    .rx_d         (lnk_d_i),
    .rx_den       (lnk_den_i),
    .rx_req       (lnk_req_i),
    .rx_busy      (lnk_busy_i),
    .rx_gnt       (lnk_gnt_i),
    .loc_wdata    (loc_wdata_i),
    .loc_drive    (loc_drive_i),
    .loc_req      (loc_req_i),
    .loc_busy     (loc_busy_i),
    .loc_gnt      (loc_gnt_i),
    .fwd_d        (fwd_d),
    .fwd_oe       (fwd_oe),
    .fwd_req      (fwd_req),
    .fwd_busy     (fwd_busy),
    .fwd_gnt      (fwd_gnt),
    .loc_rdata    (loc_rdata_o),
    .loc_req_seen (loc_req_o),
    .loc_busy_seen(loc_busy_o),
    .loc_gnt_seen (loc_gnt_o)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    lms_port_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_req(mode_req_i[p]),
      .xfer    (xfer[p]),
      .last    (rtr_last_i[p]),
      .bus_busy(bus_busy),
      .mode    (mode_o[p]),
      .pkt_mid (pkt_mid[p]),
      .sw_ok   (sw_ok[p])
    );

    lms_port_mux #(.FW(FLIT_W)) u_mux (
      .mode        (mode_o[p]),
      .rtr_flit    (rtr_flit_i[p]),
      .rtr_valid   (rtr_valid_i[p]),
      .rtr_in_ready(rtr_in_ready_i[p]),
      .rx_flit     (lnk_d_i[p][BW-1:FLIT_W]),
      .rx_valid    (lnk_valid_i[p]),
      .tx_ready    (lnk_ready_i[p]),
      .fwd_d       (fwd_d[p]),
      .fwd_oe      (fwd_oe[p]),
      .fwd_req     (fwd_req[p]),
      .fwd_busy    (fwd_busy[p]),
      .fwd_gnt     (fwd_gnt[p]),
      .lnk_d       (lnk_d_o[p]),
      .lnk_oe      (lnk_oe_o[p]),
      .lnk_valid   (lnk_valid_o[p]),
      .lnk_ready   (lnk_ready_o[p]),
      .rtr_ready   (rtr_ready_o[p]),
      .rtr_in_flit (rtr_in_flit_o[p]),
      .rtr_in_valid(rtr_in_valid_o[p]),
      .arb_req     (lnk_req_o[p]),
      .arb_busy    (lnk_busy_o[p]),
      .arb_gnt     (lnk_gnt_o[p])
    );
  end

endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int NP = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NP-1:0]       mode_req_i,
  input logic [NP-1:0]       mode_o,
  input logic [NP-1:0]       pkt_mid,
  input logic                bus_busy,
  input logic [NP-1:0]       rtr_ready_o,
  input logic [NP-1:0]       lnk_valid_o,
  input logic [NP-1:0]       rtr_in_valid_o,
  input logic [NP-1:0][1:0]  lnk_oe_o,
  input logic [NP-1:0]       lnk_req_o,
  input logic [NP-1:0]       lnk_busy_o,
  input logic [NP-1:0]       lnk_gnt_o
);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (mode_o == $past(mode_o)));

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R3
    bus_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[p] |-> (!rtr_ready_o[p] && !lnk_valid_o[p] && !rtr_in_valid_o[p]));

    // R8
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_mid[p] |=> (mode_o[p] == $past(mode_o[p])));

    // R10
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[p] != $past(mode_o[p])) |-> (mode_o[p] == $past(mode_req_i[p])));

    // R5
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_oe_o[p] != 2'b10);

    // R6
    arb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_o[p] |-> !(lnk_req_o[p] || lnk_busy_o[p] || lnk_gnt_o[p]));
  end

endmodule

bind link_mode_switch lms_checker #(.NP(NP)) u_lms_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_req_i    (mode_req_i),
  .mode_o        (mode_o),
  .pkt_mid       (pkt_mid),
  .bus_busy      (bus_busy),
  .rtr_ready_o   (rtr_ready_o),
  .lnk_valid_o   (lnk_valid_o),
  .rtr_in_valid_o(rtr_in_valid_o),
  .lnk_oe_o      (lnk_oe_o),
  .lnk_req_o     (lnk_req_o),
  .lnk_busy_o    (lnk_busy_o),
  .lnk_gnt_o     (lnk_gnt_o)
);

// File: tb/test_link_mode_switch.sv
module test_link_mode_switch;

  localparam int NP = 4;
  localparam int FW = 16;
  localparam int BW = 2 * FW;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [NP-1:0]         mode_req, mode_o;
  logic [NP-1:0][FW-1:0] rtr_flit, rtr_in_flit;
  logic [NP-1:0]         rtr_valid, rtr_last, rtr_ready, rtr_in_valid, rtr_in_ready;
  logic [NP-1:0][BW-1:0] lnk_d_o, lnk_d_i;
  logic [NP-1:0][1:0]    lnk_oe;
  logic [NP-1:0]         lnk_valid_o, lnk_ready_i, lnk_den, lnk_valid_i, lnk_ready_o;
  logic [NP-1:0]         req_o, busy_o, gnt_o, req_i, busy_i, gnt_i;
  logic [BW-1:0]         loc_wdata, loc_rdata;
  logic                  loc_drive, loc_req, loc_busy, loc_gnt;
  logic                  loc_req_o, loc_busy_o, loc_gnt_o;

  link_mode_switch #(.NP(NP), .FLIT_W(FW)) i_link_mode_switch (
    .clk(clk), .rst_n(rst_n),
    .mode_req_i(mode_req), .mode_o(mode_o),
    .rtr_flit_i(rtr_flit), .rtr_valid_i(rtr_valid), .rtr_last_i(rtr_last),
    .rtr_ready_o(rtr_ready), .rtr_in_flit_o(rtr_in_flit), .rtr_in_valid_o(rtr_in_valid),
    .rtr_in_ready_i(rtr_in_ready),
    .lnk_d_o(lnk_d_o), .lnk_oe_o(lnk_oe), .lnk_valid_o(lnk_valid_o), .lnk_ready_i(lnk_ready_i),
    .lnk_d_i(lnk_d_i), .lnk_den_i(lnk_den), .lnk_valid_i(lnk_valid_i), .lnk_ready_o(lnk_ready_o),
    .lnk_req_o(req_o), .lnk_busy_o(busy_o), .lnk_gnt_o(gnt_o),
    .lnk_req_i(req_i), .lnk_busy_i(busy_i), .lnk_gnt_i(gnt_i),
    .loc_wdata_i(loc_wdata), .loc_drive_i(loc_drive), .loc_rdata_o(loc_rdata),
    .loc_req_i(loc_req), .loc_busy_i(loc_busy), .loc_gnt_i(loc_gnt),
    .loc_req_o(loc_req_o), .loc_busy_o(loc_busy_o), .loc_gnt_o(loc_gnt_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  // Stimulus table: {mode pattern[3:0], local drives, far-side drive pattern[3:0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0000, 1'b0, 4'b0000},
    {4'b0011, 1'b1, 4'b0000},
    {4'b0011, 1'b0, 4'b0001},
    {4'b1111, 1'b0, 4'b0100},
    {4'b1010, 1'b0, 4'b1010},
    {4'b1111, 1'b1, 4'b1111},
    {4'b0110, 1'b0, 4'b0110},
    {4'b1001, 1'b1, 4'b0001}
  };

  // Bench's own view of the joined bus, from R4..R6
  task automatic check_ports(input logic [NP-1:0] m);
    logic [BW-1:0] exp_d, exp_rd;
    logic          src, er, eb, eg, lr, lb, lg;
    exp_rd = '0; lr = 1'b0; lb = 1'b0; lg = 1'b0;
    for (int q = 0; q < NP; q++) begin
      if (m[q] && lnk_den[q]) exp_rd = exp_rd | lnk_d_i[q];
      if (m[q]) begin lr = lr | req_i[q]; lb = lb | busy_i[q]; lg = lg | gnt_i[q]; end
    end
    chk_eq("R5 local read", 64'(loc_rdata), 64'(exp_rd));
    chk_eq("R6 local arb", {61'b0, loc_req_o, loc_busy_o, loc_gnt_o}, {61'b0, lr, lb, lg});
    for (int p = 0; p < NP; p++) begin
      if (!m[p]) begin
        chk_eq("R2 packet path",
               {lnk_d_o[p], lnk_oe[p], lnk_valid_o[p], lnk_ready_o[p], rtr_ready[p],
                rtr_in_valid[p], rtr_in_flit[p]},
               {{FW{1'b0}}, rtr_flit[p], 2'b01, rtr_valid[p], rtr_in_ready[p], lnk_ready_i[p],
                lnk_valid_i[p], lnk_d_i[p][BW-1:FW]});
        chk_eq("R6 packet arb quiet", {61'b0, req_o[p], busy_o[p], gnt_o[p]}, 64'd0);
      end else begin
        chk_eq("R3 bus blocks router",
               {lnk_valid_o[p], lnk_ready_o[p], rtr_ready[p], rtr_in_valid[p], rtr_in_flit[p]},
               '0);
        exp_d = loc_drive ? loc_wdata : '0;
        src = loc_drive;
        er = loc_req; eb = loc_busy; eg = loc_gnt;
        for (int q = 0; q < NP; q++) begin
          if (q != p && m[q]) begin
            if (lnk_den[q]) begin exp_d = exp_d | lnk_d_i[q]; src = 1'b1; end
            er = er | req_i[q]; eb = eb | busy_i[q]; eg = eg | gnt_i[q];
          end
        end
        chk_eq(loc_drive ? "R4 bus drive" : "R5 bus forward",
               {lnk_d_o[p], lnk_oe[p]}, {exp_d, {2{src}}});
        chk_eq("R6 bus arb", {61'b0, req_o[p], busy_o[p], gnt_o[p]}, {61'b0, er, eb, eg});
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_req = '1;
    rtr_valid = '0; rtr_last = '1; rtr_in_ready = '1;
    lnk_ready_i = 4'b1010; lnk_valid_i = '1;
    lnk_den = '0; req_i = '0; busy_i = '0; gnt_i = '0;
    loc_wdata = 32'h8040_2010; loc_drive = 1'b0;
    loc_req = 1'b0; loc_busy = 1'b0; loc_gnt = 1'b0;
    for (int q = 0; q < NP; q++) begin
      rtr_flit[q] = 16'hA000 + 16'(q);
      lnk_d_i[q]  = 32'h0101_0101 << q;
    end

    // R1: reset state, even with bus mode requested
    repeat (3) @(negedge clk);
    chk_eq("R1 reset mode", 64'(mode_o), 64'd0);
    chk_eq("R1 reset oe", 64'(lnk_oe), {56'b0, 8'b01_01_01_01});
    chk_eq("R1 reset arb", {52'b0, req_o, busy_o, gnt_o}, 64'd0);
    mode_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 after reset mode", 64'(mode_o), 64'd0);

    // Table walk: R2..R7
    for (int v = 0; v < NV; v++) begin
      rtr_valid = '0;
      mode_req  = VEC[v][8:5];
      loc_drive = VEC[v][4];
      lnk_den   = VEC[v][3:0];
      req_i     = ~VEC[v][3:0];
      gnt_i     = VEC[v][3:0];
      loc_req   = VEC[v][4];
      @(negedge clk);
      chk_eq("R7 mode pattern", 64'(mode_o), 64'(VEC[v][8:5]));
      rtr_valid = '1;
      #1;
      check_ports(VEC[v][8:5]);
      @(negedge clk);
      rtr_valid = '0;
    end
    loc_drive = 1'b0; loc_req = 1'b0; lnk_den = '0; req_i = '0; gnt_i = '0;

    // R9: local busy holds every change (current modes 1001)
    loc_busy = 1'b1;
    mode_req = 4'b0111;
    repeat (2) @(negedge clk);
    chk_eq("R9 local busy holds", 64'(mode_o), 64'b1001);
    loc_busy = 1'b0;
    busy_i = 4'b0001;
    repeat (2) @(negedge clk);
    chk_eq("R9 remote busy holds", 64'(mode_o), 64'b1001);
    busy_i = 4'b0100;
    @(negedge clk);
    chk_eq("R9 busy on packet port ignored", 64'(mode_o), 64'b0111);
    busy_i = '0;

    // R8: head flit on port 3 then pending request
    lnk_ready_i = '1;
    rtr_valid = 4'b1000; rtr_last = 4'b0111;
    @(negedge clk);
    rtr_valid = '0;
    mode_req = 4'b1111;
    repeat (3) @(negedge clk);
    chk_eq("R8 held mid packet", 64'(mode_o), 64'b0111);
    // tail handed over in the same cycle the request is pending: R10 defers
    rtr_valid = 4'b1000; rtr_last = '1;
    @(negedge clk);
    chk_eq("R10 deferred by handover", 64'(mode_o), 64'b0111);
    rtr_valid = '0;
    @(negedge clk);
    chk_eq("R10 applied next edge", 64'(mode_o), 64'b1111);

    // R10: packet-mode request meets a handover on port 1 directly
    mode_req = 4'b1101;
    @(negedge clk);
    chk_eq("R10 back to packet", 64'(mode_o), 64'b1101);
    mode_req = 4'b1111;
    rtr_valid = 4'b0010;
    @(negedge clk);
    chk_eq("R10 same-cycle handover wins", 64'(mode_o), 64'b1101);
    rtr_valid = '0;
    @(negedge clk);
    chk_eq("R10 change after handover", 64'(mode_o), 64'b1111);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule